// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Unit

This block watches the address-latch strobe of a host microcontroller bus and asks the device to enter standby once that strobe has stayed at a chosen idle level for a programmed number of counter ticks. Any movement on the strobe, or clearing the enable, takes the counter back to zero and withdraws the request.

Two byte-wide control registers sit behind a small register port. They hold the power-down enable, the idle level of the strobe, the source of the idle-counter tick and a sleep enable. They also hold a set of static gating bits that the block drives straight to its outputs. Everything runs on one system clock. The idle counter advances either on every system cycle or only on cycles where an alternate tick input is high, so the design stays fully synchronous.

The strobe goes through a two-stage synchronizer. Any difference between two successive synchronized samples counts as a pulse.

Top module: `idle_pd_unit`

## Requirements
- R1: After synchronous reset both registers read 0x00. `standby_req` and all gating outputs are 0.
- R2: A write with `reg_addr`=0 (control) or `reg_addr`=1 (source) takes effect at the clock edge that samples `reg_wr`. `reg_rdata` returns the register selected by `reg_addr`. Source-register bits 7..2 always read 0.
- R3: Control-register bits drive the outputs as follows: bit 3 drives `mem_saver_en`, bit 4 `pld_turbo_off`, bit 5 `array_clk_off` and bit 6 `mcell_clk_off`. Source-register bit 1 drives `sleep_en`. Control bits 0 and 7 are stored and read back.
- R4: While control bit 2 (power-down enable) is 0, the counter stays at zero and `standby_req` stays 0, whatever `ale_in` does.
- R5: While `ale_in` keeps toggling, `standby_req` never asserts.
- R6: With the enable set and the synchronized strobe static at the level in control bit 1 (1 = high, 0 = low), `standby_req` rises after exactly IDLE_TICKS (default 15) counter ticks.
- R7: A strobe that stays static at the level opposite to control bit 1 keeps the counter at zero.
- R8: Source-register bit 0 set to 1 gives one tick per system cycle. Set to 0, a tick occurs one cycle after each cycle with `alt_tick_in` high. With no tick the counter holds.
- R9: Once `standby_req` is set it stays set while the idle conditions hold. It drops at the third edge after `ale_in` changes (two synchronizer edges, then the clear), or at the edge after the enable bit is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ale_in | input | 1 | Bus address-latch strobe, asynchronous |
| alt_tick_in | input | 1 | Alternate counter tick enable |
| standby_req | output | 1 | Standby request |
| mem_saver_en | output | 1 | Memory current-saver enable |
| pld_turbo_off | output | 1 | Logic-array turbo disabled |
| array_clk_off | output | 1 | Array clock disconnected |
| mcell_clk_off | output | 1 | Macrocell clock disconnected |
| sleep_en | output | 1 | Sleep mode enabled |

## Verification
The bench builds the block with its defaults: IDLE_TICKS = 15 and two synchronizer stages. A terminal count of 15 lets directed tests check the exact rising edge of `standby_req`, and the saturation hold that follows it, in a few dozen cycles. Random strobe phases of 1 to 34 cycles then fall both below and above the idle threshold. Those runs take the counter repeatedly through the partial count, the clear and the saturated states, under both tick sources and both polarities.

// File: rtl/idle_pd_pkg.sv
package idle_pd_pkg;
  localparam int REG_W = 8;

  // control register bit positions
  localparam int C_POL    = 1;
  localparam int C_EN     = 2;
  localparam int C_MEMSAV = 3;
  localparam int C_TURBO  = 4;
  localparam int C_ARRCK  = 5;
  localparam int C_MCLCK  = 6;

  // source register bit positions
  localparam int S_MAIN   = 0;
  localparam int S_SLEEP  = 1;
  localparam logic [REG_W-1:0] SRC_MASK = 8'h03;

  typedef struct packed {
    logic pd_en;
    logic ale_pol;
    logic mem_saver;
    logic turbo_off;
    logic array_off;
    logic mcell_off;
    logic src_main;
    logic sleep;
  } pd_ctrl_t;
endpackage

// File: rtl/pd_ctrl_regs.sv
module pd_ctrl_regs
  import idle_pd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output pd_ctrl_t         ctrl
);
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      src_q <= '0;
    end else if (wr) begin
      if (!addr) ctl_q <= wdata;
      else       src_q <= wdata & SRC_MASK;
    end
  end

  assign rdata = addr ? src_q : ctl_q;

  always_comb begin
    ctrl.pd_en     = ctl_q[C_EN];
    ctrl.ale_pol   = ctl_q[C_POL];
    ctrl.mem_saver = ctl_q[C_MEMSAV];
    ctrl.turbo_off = ctl_q[C_TURBO];
    ctrl.array_off = ctl_q[C_ARRCK];
    ctrl.mcell_off = ctl_q[C_MCLCK];
    ctrl.src_main  = src_q[S_MAIN];
    ctrl.sleep     = src_q[S_SLEEP];
  end

  // R2: control write lands on the sampling edge
  p_ctl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && !addr) |=> (ctl_q == $past(wdata)));
  // R2: source write keeps only defined bits
  p_src_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr) |=> (src_q == ($past(wdata) & SRC_MASK)));
  // R2: no write, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(ctl_q) && $stable(src_q)));
endmodule

// File: rtl/pd_tick_sel.sv
module pd_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic src_main,
  input  logic alt_tick,
  output logic tick
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= src_main | alt_tick;
  end

  assign tick = tick_q;

  // R8: main source ticks every cycle
  p_main_tick_r8: assert property (@(posedge clk) disable iff (rst)
    src_main |=> tick);
  // R8: alternate source without pulse gives no tick
  p_alt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!src_main && !alt_tick) |=> !tick);
endmodule

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
  parameter int IDLE_TICKS  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ale_in,
  input  logic tick,
  input  logic pd_en,
  input  logic ale_pol,
  output logic standby
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] TERM = CW'(IDLE_TICKS);

  // synchronizer chain plus one history stage
  logic [SYNC_STAGES:0] smp;

  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) smp[0] <= 1'b0;
        else     smp[0] <= ale_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) smp[g] <= 1'b0;
        else     smp[g] <= smp[g-1];
      end
    end
  end

  logic level, edge_seen, at_idle;
  assign level     = smp[SYNC_STAGES-1];
  assign edge_seen = smp[SYNC_STAGES-1] ^ smp[SYNC_STAGES];
  assign at_idle   = pd_en && !edge_seen && (level == ale_pol);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stby_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!at_idle)
      cnt_d = '0;
    else if (tick && (cnt_q != TERM))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      stby_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stby_q <= (cnt_d == TERM);
    end
  end

  assign standby = stby_q;

  // R4: disabled unit never counts
  p_no_count_r4: assert property (@(posedge clk) disable iff (rst)
    !pd_en |=> (cnt_q == '0));
  // R5: a strobe pulse clears the counter
  p_pulse_clear_r5: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> (cnt_q == '0));
  // R7: wrong static level keeps counter at zero
  p_wrong_level_r7: assert property (@(posedge clk) disable iff (rst)
    (pd_en && !edge_seen && (level != ale_pol)) |=> (cnt_q == '0));
  // R6: one step per tick while idle
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (at_idle && tick && (cnt_q != TERM)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8: no tick, no change
  p_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (at_idle && !tick) |=> $stable(cnt_q));
  // R9: saturated count holds while idle
  p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (at_idle && (cnt_q == TERM)) |=> (cnt_q == TERM) && standby);
endmodule

// File: rtl/idle_pd_unit.sv
module idle_pd_unit
  import idle_pd_pkg::*;
#(
  parameter int IDLE_TICKS  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ale_in,
  input  logic             alt_tick_in,
  output logic             standby_req,
  output logic             mem_saver_en,
  output logic             pld_turbo_off,
  output logic             array_clk_off,
  output logic             mcell_clk_off,
  output logic             sleep_en
);
  pd_ctrl_t ctrl;
  logic     tick;

  pd_ctrl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  pd_tick_sel u_tick (
    .clk      (clk),
    .rst      (rst),
    .src_main (ctrl.src_main),
    .alt_tick (alt_tick_in),
    .tick     (tick)
  );

  pd_idle_timer #(
    .IDLE_TICKS  (IDLE_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .ale_in  (ale_in),
    .tick    (tick),
    .pd_en   (ctrl.pd_en),
    .ale_pol (ctrl.ale_pol),
    .standby (standby_req)
  );

  assign mem_saver_en  = ctrl.mem_saver;
  assign pld_turbo_off = ctrl.turbo_off;
  assign array_clk_off = ctrl.array_off;
  assign mcell_clk_off = ctrl.mcell_off;
  assign sleep_en      = ctrl.sleep;

  // R1: nothing requested in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!standby_req && !sleep_en && !mem_saver_en));
endmodule

// File: tb/idle_pd_unit_test.sv
module idle_pd_unit_test;
  localparam int TICKS = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ale_in = 1'b0;
  logic       alt_tick_in = 1'b0;
  logic       standby_req, mem_saver_en, pld_turbo_off;
  logic       array_clk_off, mcell_clk_off, sleep_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  idle_pd_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale_in(ale_in),
    .alt_tick_in(alt_tick_in), .standby_req(standby_req),
    .mem_saver_en(mem_saver_en), .pld_turbo_off(pld_turbo_off),
    .array_clk_off(array_clk_off), .mcell_clk_off(mcell_clk_off),
    .sleep_en(sleep_en)
  );

  // reference model built from the requirements
  logic [7:0] m_ctl, m_src;
  logic       m_s1, m_s2, m_s3, m_tick;
  int         m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_ctl <= '0; m_src <= '0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
      m_tick <= 0; m_cnt <= 0;
    end else begin
      if (reg_wr) begin
        if (!reg_addr) m_ctl <= reg_wdata;
        else           m_src <= reg_wdata & 8'h03;
      end
      m_s1 <= ale_in; m_s2 <= m_s1; m_s3 <= m_s2;
      m_tick <= m_src[0] | alt_tick_in;
      if (!m_ctl[2] || (m_s2 != m_s3) || (m_s2 != m_ctl[1])) m_cnt <= 0;
      else if (m_tick && m_cnt != TICKS) m_cnt <= m_cnt + 1;
    end
  end

  function automatic logic [7:0] exp_read(input logic a, input logic [7:0] c,
                                          input logic [7:0] s);
    return a ? (s & 8'h03) : c;
  endfunction

  function automatic logic [4:0] exp_gates(input logic [7:0] c, input logic [7:0] s);
    return {c[3], c[4], c[5], c[6], s[1]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hold_no_standby(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (standby_req) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; reg_wr = 0; ale_in = 0; alt_tick_in = 0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // random-phase comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      check("R6 standby vs model", standby_req, (m_cnt == TICKS));
      check("R2 readback vs model", reg_rdata, exp_read(reg_addr, m_ctl, m_src));
      check("R3 gates vs model",
            {mem_saver_en, pld_turbo_off, array_clk_off, mcell_clk_off, sleep_en},
            exp_gates(m_ctl, m_src));
    end
  end

  initial begin
    int phase;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    reg_addr = 0; cyc(1);
    check("R1 ctl after reset", reg_rdata, 8'h00);
    reg_addr = 1; cyc(1);
    check("R1 src after reset", reg_rdata, 8'h00);
    check("R1 standby after reset", standby_req, 0);
    check("R1 gates after reset",
          {mem_saver_en, pld_turbo_off, array_clk_off, mcell_clk_off, sleep_en}, 5'b0);

    // R2/R3: register access and gating
    wr_reg(0, 8'hF9);
    reg_addr = 0;
    check("R2 ctl readback", reg_rdata, 8'hF9);
    check("R3 gates from ctl", {mem_saver_en, pld_turbo_off, array_clk_off, mcell_clk_off},
          4'b1111);
    wr_reg(1, 8'hFE);
    reg_addr = 1;
    check("R2 src reserved bits", reg_rdata, 8'h02);
    check("R3 sleep_en", sleep_en, 1);
    wr_reg(1, 8'h01);
    check("R3 sleep_en cleared", sleep_en, 0);

    // R4: disabled, strobe high at matching polarity
    ale_in = 1;
    wr_reg(0, 8'h83);
    hold_no_standby("R4 disabled no standby", 40);

    // R6: exact count
    wr_reg(0, 8'h87);
    cyc(TICKS - 1);
    check("R6 standby one tick early", standby_req, 0);
    cyc(1);
    check("R6 standby at terminal", standby_req, 1);

    // R9: saturation then strobe edge
    cyc(10);
    check("R9 standby holds", standby_req, 1);
    ale_in = 0;
    cyc(2);
    check("R9 standby before clear", standby_req, 1);
    cyc(1);
    check("R9 standby cleared by edge", standby_req, 0);

    // R7: static at opposite level
    hold_no_standby("R7 wrong level", 40);

    // R9: enable cleared
    ale_in = 1;
    cyc(30);
    check("R9 standby rebuilt", standby_req, 1);
    wr_reg(0, 8'h83);
    check("R9 standby in write cycle", standby_req, 1);
    cyc(1);
    check("R9 standby cleared by enable", standby_req, 0);

    // R5: toggling strobe
    wr_reg(0, 8'h87);
    for (int i = 0; i < 30; i++) begin
      ale_in = ~ale_in;
      hold_no_standby("R5 toggling", 2);
    end
    ale_in = 1;

    // R8: alternate tick source
    wr_reg(1, 8'h00);
    wr_reg(0, 8'h83);
    wr_reg(0, 8'h87);
    hold_no_standby("R8 no alt ticks", 40);
    for (int i = 0; i < TICKS; i++) begin
      if (i == TICKS - 1) check("R8 one alt tick short", standby_req, 0);
      alt_tick_in = 1; cyc(1);
      alt_tick_in = 0; cyc(1);
    end
    check("R8 standby after alt ticks", standby_req, 1);

    // random phase against the model
    do_reset();
    model_on = 1'b1;
    phase = 0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      #1;
      if (phase == 0) begin
        ale_in = ~ale_in;
        phase = ($urandom % 4 == 0) ? 1 + ($urandom % 3) : 5 + ($urandom % 30);
      end else phase--;
      alt_tick_in = ($urandom % 3 == 0);
      reg_wr = ($urandom % 48 == 0);
      reg_addr = $urandom % 2;
      if (!reg_addr) begin
        reg_wdata = 8'($urandom);
        reg_wdata[0] = 1; reg_wdata[7] = 1;
        reg_wdata[2] = ($urandom % 4 != 0);
      end else reg_wdata = 8'($urandom);
    end
    @(negedge clk);
    model_on = 1'b0;
    reg_wr = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule